// File: doc/BRIEF.md
# Interrupt Router Register Window

This block is the bus-facing register front end of an interrupt router. A processor reaches it through three 32-bit locations on a simple single-cycle bus: a select register that holds an index, a data window that reads or writes whatever that index names, and an end-of-interrupt location. Behind the window sit an identification register, a read-only version word that reports how many pins the router has, a read-only arbitration word, and a table holding one 64-bit routing entry per pin. Software moves each entry as two 32-bit halves.

Two status bits in every routing entry belong to the delivery logic, so bus writes cannot change them. After reset every entry is masked. Two strobes report events to the neighbouring blocks, each for one cycle. An end-of-interrupt write carries its vector to the dispatch block. A routing-entry write carries the pin number and the entry's old and new contents. Interrupt delivery itself lives elsewhere.

Top module: `irq_window_regs`

## Requirements
- R1: A full-word access at byte offset 0x00 reads or writes the select register. The register holds only the low 8 bits of the written data. An offset of 0x10 reaches the data window, and 0x40 reaches the end-of-interrupt location.
- R2: An access whose size code is not 4 (bytes) has no effect. Any access to an offset other than 0x00, 0x10 or 0x40 also has no effect. When such an access is a read, it returns zero.
- R3: Read data appears with `rdValid` high in the cycle after the read request. `rdValid` stays low after writes.
- R4: A window read with select index 0 or 2 returns the ID field in bits 27:24, with all other bits zero. A window write at index 0 stores data bits 27:24 into the ID field. Window writes at index 1 and index 2 change nothing.
- R5: A window read at index 1 returns (PIN_COUNT-1) in bits 23:16, ORed with 0x11. For 24 pins this is 0x00170011.
- R6: Index 0x10+2p reaches bits 31:0 of pin p's entry, and index 0x11+2p reaches bits 63:32. A write replaces only the addressed half.
- R7: On an entry write, bit 14 (remote request pending) and bit 12 (delivery in progress) keep their stored values. Every other bit of the addressed half takes the written data.
- R8: After reset, the select register and the ID field read zero, every entry holds 0x0001000000010000, and all strobes and `rdValid` are low.
- R9: A window read at an index that is neither 0, 1 or 2 nor inside the table returns zero. A window write at such an index changes nothing and raises no strobe.
- R10: A full-word write at offset 0x40 raises `eoiStrobe` for exactly one cycle, starting the cycle after the write. `eoiVector` carries data bits 7:0. A read at offset 0x40 returns zero.
- R11: Each entry write raises `entryWrStrobe` for one cycle, starting the cycle after the write. In that cycle, `entryWrPin` gives the pin, `entryWrOld` the entry before the write, and `entryWrNew` the entry after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Access request, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the access |
| busSize | input | 3 | Access size in bytes |
| busWdata | input | 32 | Write data |
| rdValid | output | 1 | Read data valid, one cycle after a read |
| rdData | output | 32 | Read data |
| eoiStrobe | output | 1 | End-of-interrupt pulse to the dispatch block |
| eoiVector | output | VEC_W | Vector of that end-of-interrupt |
| entryWrStrobe | output | 1 | Routing-entry write pulse |
| entryWrPin | output | PIN_W | Pin whose entry was written |
| entryWrOld | output | 64 | Entry contents before the write |
| entryWrNew | output | 64 | Entry contents after the write |

## Verification
The assertions assume the bus presents at most one access per cycle. They also assume that `busWrite`, `busAddr` and `busSize` are known whenever `busValid` is high. A read therefore always has a well-defined decode in the cycle that produces its data. The bench drives every access for exactly one cycle and then drops `busValid`. It keeps the select index stable around each window access, so every strobe and every read result can be traced to a single request. It also issues narrow accesses of sizes 1 and 2, accesses to undecoded offsets, and indices just beyond the table. These show that ignored accesses leave the stored state untouched.

// File: rtl/irw_pkg.sv
package irw_pkg;

  // Byte offsets of the three bus-visible locations.
  localparam logic [7:0] OFF_SELECT = 8'h00;
  localparam logic [7:0] OFF_WINDOW = 8'h10;
  localparam logic [7:0] OFF_EOI    = 8'h40;

  // Size code of the only access width that takes effect.
  localparam logic [2:0] FULL_WORD = 3'd4;

  // Window index layout.
  localparam int IDX_ID      = 0;
  localparam int IDX_VERSION = 1;
  localparam int IDX_ARB     = 2;
  localparam int TABLE_BASE  = 16;

  // Field positions inside the 32-bit words.
  localparam int ID_LSB     = 24;
  localparam int MAXENT_LSB = 16;
  localparam logic [31:0] VERSION_CODE = 32'h0000_0011;

  // Status bits owned by the delivery logic: bit 14 pending, bit 12 busy.
  localparam logic [63:0] RO_MASK     = 64'h0000_0000_0000_5000;
  localparam logic [63:0] ENTRY_RESET = 64'h0001_0000_0001_0000;

  // One-hot action decoded from a bus request.
  typedef struct packed {
    logic selWr;
    logic selRd;
    logic winWr;
    logic winRd;
    logic eoiWr;
    logic nullRd;
  } winStrobe_t;

endpackage

// File: rtl/irw_ctrl.sv
module irw_ctrl
  import irw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        busSize,
  output winStrobe_t        str
);

  logic fullWord;
  logic atSel;
  logic atWin;
  logic atEoi;

  always_comb begin
    fullWord = busValid && (busSize == FULL_WORD);
    atSel    = (busAddr == ADDR_W'(OFF_SELECT));
    atWin    = (busAddr == ADDR_W'(OFF_WINDOW));
    atEoi    = (busAddr == ADDR_W'(OFF_EOI));

    str.selWr  = fullWord &&  busWrite && atSel;
    str.selRd  = fullWord && !busWrite && atSel;
    str.winWr  = fullWord &&  busWrite && atWin;
    str.winRd  = fullWord && !busWrite && atWin;
    str.eoiWr  = fullWord &&  busWrite && atEoi;
    str.nullRd = busValid && !busWrite && !(fullWord && (atSel || atWin));
  end

  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(str)); // R1

  AST_NARROW_NO_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busSize != FULL_WORD) |-> !(str.selWr || str.selRd || str.winWr || str.winRd || str.eoiWr)); // R2

endmodule

// File: rtl/irw_datapath.sv
module irw_datapath
  import irw_pkg::*;
#(
  parameter int PIN_COUNT = 24,
  parameter int SEL_W     = 8,
  parameter int ID_W      = 4,
  parameter int VEC_W     = 8,
  localparam int PIN_W    = (PIN_COUNT > 1) ? $clog2(PIN_COUNT) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  winStrobe_t       str,
  input  logic [31:0]      busWdata,
  output logic             rdValid,
  output logic [31:0]      rdData,
  output logic             eoiStrobe,
  output logic [VEC_W-1:0] eoiVector,
  output logic             entryWrStrobe,
  output logic [PIN_W-1:0] entryWrPin,
  output logic [63:0]      entryWrOld,
  output logic [63:0]      entryWrNew
);

  localparam int TABLE_END = TABLE_BASE + 2 * PIN_COUNT;
  localparam logic [31:0] VERSION_WORD =
    (32'(PIN_COUNT - 1) << MAXENT_LSB) | VERSION_CODE;

  logic [SEL_W-1:0] selReg;
  logic [ID_W-1:0]  idReg;
  logic [63:0]      entryView [PIN_COUNT];

  // Index decode of the current select value.
  logic             inTable;
  logic [SEL_W-1:0] tblOff;
  logic [PIN_W-1:0] pinSel;
  logic             halfSel;
  logic [63:0]      curEntry;
  logic [63:0]      wideWrite;
  logic [63:0]      nextEntry;
  logic             tblWr;
  logic             idWr;

  always_comb begin
    inTable = (int'(selReg) >= TABLE_BASE) && (int'(selReg) < TABLE_END);
    tblOff  = selReg - SEL_W'(TABLE_BASE);
    pinSel  = tblOff[PIN_W:1];
    halfSel = tblOff[0];
    curEntry = inTable ? entryView[pinSel] : '0;
    wideWrite = halfSel ? {busWdata, curEntry[31:0]} : {curEntry[63:32], busWdata};
    nextEntry = (wideWrite & ~RO_MASK) | (curEntry & RO_MASK);
    tblWr = str.winWr && inTable;
    idWr  = str.winWr && (selReg == SEL_W'(IDX_ID));
  end

  // Per-pin routing entry storage.
  genvar p;
  generate
    for (p = 0; p < PIN_COUNT; p++) begin : g_entry
      logic [63:0] entryQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          entryQ <= ENTRY_RESET;
        end else if (tblWr && (pinSel == PIN_W'(p))) begin
          entryQ <= nextEntry;
        end
      end
      assign entryView[p] = entryQ;
    end
  endgenerate

  // Select and ID registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      idReg  <= '0;
    end else begin
      if (str.selWr) selReg <= busWdata[SEL_W-1:0];
      if (idWr)      idReg  <= busWdata[ID_LSB +: ID_W];
    end
  end

  // Read mux.
  logic [31:0] winData;
  logic [31:0] rdNext;

  always_comb begin
    if ((selReg == SEL_W'(IDX_ID)) || (selReg == SEL_W'(IDX_ARB))) begin
      winData = 32'(idReg) << ID_LSB;
    end else if (selReg == SEL_W'(IDX_VERSION)) begin
      winData = VERSION_WORD;
    end else if (inTable) begin
      winData = halfSel ? curEntry[63:32] : curEntry[31:0];
    end else begin
      winData = '0;
    end

    if (str.selRd)      rdNext = 32'(selReg);
    else if (str.winRd) rdNext = winData;
    else                rdNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= str.selRd || str.winRd || str.nullRd;
      rdData  <= rdNext;
    end
  end

  // Event strobes to the neighbouring blocks.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eoiStrobe     <= 1'b0;
      eoiVector     <= '0;
      entryWrStrobe <= 1'b0;
      entryWrPin    <= '0;
      entryWrOld    <= '0;
      entryWrNew    <= '0;
    end else begin
      eoiStrobe     <= str.eoiWr;
      entryWrStrobe <= tblWr;
      if (str.eoiWr) eoiVector <= busWdata[VEC_W-1:0];
      if (tblWr) begin
        entryWrPin <= pinSel;
        entryWrOld <= curEntry;
        entryWrNew <= nextEntry;
      end
    end
  end

  AST_RO_BITS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    entryWrStrobe |-> (((entryWrNew ^ entryWrOld) & RO_MASK) == '0)); // R7

  AST_ONE_HALF_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    entryWrStrobe |-> ((entryWrNew[63:32] == entryWrOld[63:32]) || (entryWrNew[31:0] == entryWrOld[31:0]))); // R6

  AST_TABLE_MATCHES_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    entryWrStrobe |-> (entryView[entryWrPin] == entryWrNew)); // R11

  AST_NULL_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(str.nullRd)) |-> (rdData == '0)); // R2

  AST_EOI_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    !(eoiStrobe && entryWrStrobe)); // R10

endmodule

// File: rtl/irq_window_regs.sv
module irq_window_regs
  import irw_pkg::*;
#(
  parameter int PIN_COUNT = 24,
  parameter int ADDR_W    = 8,
  parameter int SEL_W     = 8,
  parameter int ID_W      = 4,
  parameter int VEC_W     = 8,
  localparam int PIN_W    = (PIN_COUNT > 1) ? $clog2(PIN_COUNT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        busSize,
  input  logic [31:0]       busWdata,
  output logic              rdValid,
  output logic [31:0]       rdData,
  output logic              eoiStrobe,
  output logic [VEC_W-1:0]  eoiVector,
  output logic              entryWrStrobe,
  output logic [PIN_W-1:0]  entryWrPin,
  output logic [63:0]       entryWrOld,
  output logic [63:0]       entryWrNew
);

  winStrobe_t str;

  irw_ctrl #(
    .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busSize  (busSize),
    .str      (str)
  );

  irw_datapath #(
    .PIN_COUNT(PIN_COUNT),
    .SEL_W    (SEL_W),
    .ID_W     (ID_W),
    .VEC_W    (VEC_W)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .str           (str),
    .busWdata      (busWdata),
    .rdValid       (rdValid),
    .rdData        (rdData),
    .eoiStrobe     (eoiStrobe),
    .eoiVector     (eoiVector),
    .entryWrStrobe (entryWrStrobe),
    .entryWrPin    (entryWrPin),
    .entryWrOld    (entryWrOld),
    .entryWrNew    (entryWrNew)
  );

endmodule

// File: tb/irq_window_regs_tb_top.sv
`timescale 1ns/1ps
module irq_window_regs_tb_top;

  localparam int PIN_COUNT = 24;
  localparam int PIN_W = $clog2(PIN_COUNT);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [2:0]  busSize = '0;
  logic [31:0] busWdata = '0;
  logic        rdValid;
  logic [31:0] rdData;
  logic        eoiStrobe;
  logic [7:0]  eoiVector;
  logic        entryWrStrobe;
  logic [PIN_W-1:0] entryWrPin;
  logic [63:0] entryWrOld;
  logic [63:0] entryWrNew;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irq_window_regs #(.PIN_COUNT(PIN_COUNT)) dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .rdValid(rdValid), .rdData(rdData), .eoiStrobe(eoiStrobe),
    .eoiVector(eoiVector), .entryWrStrobe(entryWrStrobe),
    .entryWrPin(entryWrPin), .entryWrOld(entryWrOld), .entryWrNew(entryWrNew)
  );

  // Vector layout: {write, offset[7:0], size[2:0], wdata[31:0], expected read[31:0]}
  localparam int NV = 34;
  localparam logic [75:0] VEC [NV] = '{
    {1'b0, 8'h00, 3'd4, 32'h0000_0000, 32'h0000_0000},
    {1'b1, 8'h00, 3'd4, 32'h0000_01FF, 32'h0},
    {1'b0, 8'h00, 3'd4, 32'h0,         32'h0000_00FF},
    {1'b1, 8'h00, 3'd4, 32'h0000_0000, 32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,         32'h0000_0000},
    {1'b1, 8'h10, 3'd4, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,         32'h0F00_0000},
    {1'b1, 8'h00, 3'd4, 32'h0000_0002, 32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,         32'h0F00_0000},
    {1'b1, 8'h10, 3'd4, 32'h0000_0000, 32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,         32'h0F00_0000},
    {1'b1, 8'h00, 3'd4, 32'h0000_0001, 32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,         32'h0017_0011},
    {1'b1, 8'h10, 3'd4, 32'h0000_0000, 32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,         32'h0017_0011},
    {1'b1, 8'h00, 3'd4, 32'h0000_0010, 32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,         32'h0001_0000},
    {1'b1, 8'h00, 3'd4, 32'h0000_0011, 32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,         32'h0001_0000},
    {1'b1, 8'h00, 3'd4, 32'h0000_003F, 32'h0},
    {1'b1, 8'h10, 3'd4, 32'hAABB_CCDD, 32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,         32'hAABB_CCDD},
    {1'b1, 8'h00, 3'd4, 32'h0000_003E, 32'h0},
    {1'b1, 8'h10, 3'd4, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,         32'hFFFF_AFFF},
    {1'b1, 8'h00, 3'd4, 32'h0000_0040, 32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,         32'h0000_0000},
    {1'b1, 8'h00, 3'd4, 32'h0000_0005, 32'h0},
    {1'b0, 8'h10, 3'd4, 32'h0,         32'h0000_0000},
    {1'b0, 8'h10, 3'd2, 32'h0,         32'h0000_0000},
    {1'b1, 8'h00, 3'd1, 32'h0000_0010, 32'h0},
    {1'b0, 8'h00, 3'd4, 32'h0,         32'h0000_0005},
    {1'b0, 8'h20, 3'd4, 32'h0,         32'h0000_0000},
    {1'b0, 8'h40, 3'd4, 32'h0,         32'h0000_0000}
  };

  localparam string VTAG [NV] = '{
    "R8 select reset", "R1 select write", "R1 select keeps low 8 bits", "R1 select write",
    "R8 ID reset", "R4 ID write", "R4 ID read index 0", "R1 select write",
    "R4 ID read index 2", "R4 arbitration write", "R4 arbitration write ignored", "R1 select write",
    "R5 version word", "R4 version write", "R4 version write ignored", "R1 select write",
    "R8 entry low reset", "R1 select write", "R8 entry high reset", "R1 select write",
    "R6 high half write", "R6 high half readback", "R1 select write", "R7 low half write",
    "R7 status bits kept", "R1 select write", "R9 index past table", "R1 select write",
    "R9 unknown index", "R2 narrow window read", "R2 narrow select write", "R2 select unchanged",
    "R2 undecoded offset", "R10 eoi read"
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one access for one cycle; outputs registered at that edge are then visible.
  task automatic access(input logic wr, input logic [7:0] addr, input logic [2:0] size,
                        input logic [31:0] data);
    busValid = 1'b1;
    busWrite = wr;
    busAddr  = addr;
    busSize  = size;
    busWdata = data;
    @(posedge clk);
    #1;
    busValid = 1'b0;
    busWrite = 1'b0;
    busWdata = '0;
  endtask

  task automatic idle();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R8: outputs at reset
    check("R8 rdValid at reset", 64'(rdValid), 64'd0);
    check("R8 eoiStrobe at reset", 64'(eoiStrobe), 64'd0);
    check("R8 entryWrStrobe at reset", 64'(entryWrStrobe), 64'd0);
    rstN = 1'b1;
    idle();

    for (int i = 0; i < NV; i++) begin
      logic [75:0] v;
      v = VEC[i];
      access(v[75], v[74:67], v[66:64], v[63:32]);
      if (v[75]) begin
        check({VTAG[i], " (R3 no read data after write)"}, 64'(rdValid), 64'd0);
      end else begin
        check({VTAG[i], " (R3 valid)"}, 64'(rdValid), 64'd1);
        check(VTAG[i], 64'(rdData), 64'(v[31:0]));
      end
    end

    // R10: EOI strobe with vector, single cycle
    access(1'b1, 8'h40, 3'd4, 32'h1234_5631);
    check("R10 eoi strobe", 64'(eoiStrobe), 64'd1);
    check("R10 eoi vector", 64'(eoiVector), 64'h31);
    idle();
    check("R10 eoi strobe one cycle", 64'(eoiStrobe), 64'd0);

    // R2: narrow EOI write raises nothing
    access(1'b1, 8'h40, 3'd2, 32'h0000_0077);
    check("R2 narrow eoi ignored", 64'(eoiStrobe), 64'd0);

    // R11: entry strobe for pin 1 high half
    access(1'b1, 8'h00, 3'd4, 32'h0000_0013);
    access(1'b1, 8'h10, 3'd4, 32'hDEAD_BEEF);
    check("R11 entry strobe", 64'(entryWrStrobe), 64'd1);
    check("R11 entry pin", 64'(entryWrPin), 64'd1);
    check("R11 entry old", entryWrOld, 64'h0001_0000_0001_0000);
    check("R11 entry new", entryWrNew, 64'hDEAD_BEEF_0001_0000);
    idle();
    check("R11 entry strobe one cycle", 64'(entryWrStrobe), 64'd0);

    // R7: status bits stay clear when written as ones
    access(1'b1, 8'h00, 3'd4, 32'h0000_0012);
    access(1'b1, 8'h10, 3'd4, 32'h0000_5000);
    check("R7 new entry keeps status bits", entryWrNew, 64'hDEAD_BEEF_0000_0000);

    // R9: window write beyond the table raises no strobe
    access(1'b1, 8'h00, 3'd4, 32'h0000_0040);
    access(1'b1, 8'h10, 3'd4, 32'h1111_1111);
    check("R9 no strobe outside table", 64'(entryWrStrobe), 64'd0);

    // R2: narrow window write leaves the entry intact
    access(1'b1, 8'h00, 3'd4, 32'h0000_003F);
    access(1'b1, 8'h10, 3'd2, 32'h0000_0000);
    check("R2 narrow window write no strobe", 64'(entryWrStrobe), 64'd0);
    access(1'b0, 8'h10, 3'd4, 32'h0);
    check("R2 entry unchanged after narrow write", 64'(rdData), 64'hAABB_CCDD);

    // R6: pin 1 low half reads back the protected write
    access(1'b1, 8'h00, 3'd4, 32'h0000_0012);
    access(1'b0, 8'h10, 3'd4, 32'h0);
    check("R6 pin 1 low half", 64'(rdData), 64'h0000_0000);
    idle();
    check("R3 rdValid drops after read", 64'(rdValid), 64'd0);

    summary();
  end

endmodule